// File: doc/BRIEF.md
# Receive and Transmit Byte Queues with Fill-Level Interrupts

This block holds characters between a serial line and the processor side of a serial port. One queue collects received characters, each tagged with four error bits. The other queue holds characters waiting to be sent. A serializer, outside this block, pushes into the receive queue and pops from the transmit queue. A register bus, also outside this block, pops received entries and pushes characters to send.

Each queue raises a level interrupt based on its fill. The receive interrupt is active while the fill is at or above a selectable fraction of the depth. The transmit interrupt is active while the fill is at or below such a fraction. A receive-idle timer reports characters that have been left unread for a fixed number of bit periods. When queue mode is switched off, each direction holds exactly one entry. Every change of that mode empties both queues.

The idle timer is a three-state machine:
- TMR_IDLE: receive queue empty.
- TMR_COUNT: entries present, counting bit ticks.
- TMR_FIRED: timeout reported.

Its transitions are:
- IDLE→COUNT: when the queue becomes non-empty.
- COUNT→FIRED: on the last tick of the window.
- COUNT/FIRED→IDLE: when the queue is empty.
- FIRED→COUNT: on any push, pop or flush.
- COUNT→COUNT with the counter restarted: on activity.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty. `stat_flags` reads 4'b1001, `rx_irq` and `rx_timeout` are low, and `tx_irq` is high.
- R2: Entries leave each queue in the order they were accepted. A receive entry carries the data in [7:0], framing error in [8], parity error in [9], break in [10] and overrun in [11].
- R3: In queue mode each queue holds DEPTH entries. `stat_flags` holds [0] receive empty, [1] transmit full, [2] receive full and [3] transmit empty. A push to a full transmit queue is dropped.
- R4: A receive push while the queue is full and no pop is made is dropped. It sets bit [11] of the newest stored entry.
- R5: `rx_irq` is high while the receive fill is at least the level picked by `lvl_sel[5:3]`. The codes are 0:DEPTH/8, 1:DEPTH/4, 2:DEPTH/2, 3:3·DEPTH/4 and 4..7:7·DEPTH/8.
- R6: `tx_irq` is high while the transmit fill is at most the level picked by `lvl_sel[2:0]`, using the same code table as R5.
- R7: With `fifo_en` low each queue holds one entry. `rx_irq` then means not empty, `tx_irq` means empty, and a second receive push sets overrun on the held entry.
- R8: `rx_timeout` rises after TOUT_BITS `bit_tick` pulses with the receive queue non-empty and no push or pop. It falls in the cycle after any push or pop and is never high while the receive queue is empty.
- R9: A push and a pop in the same cycle on a full queue both take effect. The fill stays at full and no overrun is marked.
- R10: A change of `fifo_en` empties both queues by the next cycle, taking precedence over a push in that cycle.
- R11: A pop from an empty queue is ignored, and later data is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: queue mode; 0: single-entry mode |
| lvl_sel | input | 6 | [5:3] receive level code, [2:0] transmit level code |
| bit_tick | input | 1 | One pulse per serial bit period |
| rx_push | input | 1 | Received character strobe |
| rx_push_data | input | 8 | Received character |
| rx_push_err | input | 3 | {break, parity, framing} for the character |
| rx_pop | input | 1 | Remove oldest receive entry |
| rx_pop_data | output | 12 | Oldest receive entry |
| tx_push | input | 1 | Queue a character for sending |
| tx_push_data | input | 8 | Character to send |
| tx_pop | input | 1 | Remove oldest transmit entry |
| tx_pop_data | output | 8 | Oldest transmit entry |
| stat_flags | output | 4 | Queue flags, layout in R3 |
| rx_irq | output | 1 | Receive level interrupt |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_timeout | output | 1 | Receive idle timeout |

## Verification
Two functions can meet in one cycle: the acceptance of a new receive character and the overrun marking of the newest entry. Both are decided in the edge where a push meets a full queue. The case is provoked by filling the receive queue and then pushing with and without a simultaneous pop. With the pop, the new character must appear at the tail with a clean overrun bit. Without it, the character must vanish and the previous tail must carry the overrun bit. A second collision is a push landing on the last tick of the idle window, and the timeout must not rise there.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    localparam int RX_ENTRY_W = 12;
    localparam int BIT_FRM    = 8;
    localparam int BIT_PAR    = 9;
    localparam int BIT_BRK    = 10;
    localparam int BIT_OVR    = 11;

    // fill level selected by a 3-bit code, as a fraction of the depth
    function automatic int unsigned level_of(input logic [2:0] code, input int unsigned depth);
        unique case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
    parameter int W        = 8,
    parameter int DEPTH    = 16,
    parameter bit MARK_OVR = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       single,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cap;
    logic          do_push, do_pop, ovr_hit;

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign empty   = (cnt == '0);
    assign full    = (cnt == cap);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign count   = cnt;
    assign dout    = mem[rd_ptr];

    generate
        if (MARK_OVR) begin : g_ovr
            assign ovr_hit = push && !do_push && !flush;
        end else begin : g_no_ovr
            assign ovr_hit = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && do_push)
            mem[wr_ptr] <= din;
        if (ovr_hit)
            mem[wr_ptr - AW'(1)][W-1] <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R3

    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (cnt == $past(cnt))); // R4

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty); // R11

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop && !flush) |=> (cnt == $past(cnt))); // R9

endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer
    import uart_fifo_pkg::*;
#(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_empty,
    input  logic activity,
    input  logic bit_tick,
    output logic timeout
);
    localparam int TW = $clog2(LIMIT + 1);

    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                cnt_d = '0;
                if (!rx_empty) state_d = TMR_COUNT;
            end
            TMR_COUNT: begin
                if (rx_empty) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else if (activity) begin
                    cnt_d = '0;
                end else if (bit_tick) begin
                    if (cnt_q == TW'(LIMIT - 1)) begin
                        state_d = TMR_FIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + TW'(1);
                    end
                end
            end
            TMR_FIRED: begin
                cnt_d = '0;
                if (rx_empty)      state_d = TMR_IDLE;
                else if (activity) state_d = TMR_COUNT;
            end
            default: begin
                state_d = TMR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        timeout = (state_q == TMR_FIRED);
    end

    AST_TOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !timeout); // R8

    AST_TOUT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !rx_empty); // R8

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TOUT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic [5:0]  lvl_sel,
    input  logic        bit_tick,
    input  logic        rx_push,
    input  logic [7:0]  rx_push_data,
    input  logic [2:0]  rx_push_err,
    input  logic        rx_pop,
    output logic [11:0] rx_pop_data,
    input  logic        tx_push,
    input  logic [7:0]  tx_push_data,
    input  logic        tx_pop,
    output logic [7:0]  tx_pop_data,
    output logic [3:0]  stat_flags,
    output logic        rx_irq,
    output logic        tx_irq,
    output logic        rx_timeout
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          en_q, flush;
    logic [CW-1:0] rx_cnt, tx_cnt, rx_thr, tx_thr;
    logic          rx_full, rx_empty, tx_full, tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= fifo_en;
    end
    assign flush = (fifo_en != en_q);

    uart_fifo_store #(.W(RX_ENTRY_W), .DEPTH(DEPTH), .MARK_OVR(1'b1)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .single(!fifo_en),
        .push  (rx_push),
        .din   ({1'b0, rx_push_err, rx_push_data}),
        .pop   (rx_pop),
        .dout  (rx_pop_data),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_fifo_store #(.W(8), .DEPTH(DEPTH), .MARK_OVR(1'b0)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .single(!fifo_en),
        .push  (tx_push),
        .din   (tx_push_data),
        .pop   (tx_pop),
        .dout  (tx_pop_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_rx_idle_timer #(.LIMIT(TOUT_BITS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_empty(rx_empty),
        .activity(rx_push || rx_pop || flush),
        .bit_tick(bit_tick),
        .timeout (rx_timeout)
    );

    always_comb begin
        rx_thr = fifo_en ? CW'(level_of(lvl_sel[5:3], DEPTH)) : CW'(1);
        tx_thr = fifo_en ? CW'(level_of(lvl_sel[2:0], DEPTH)) : CW'(0);
    end

    assign rx_irq     = (rx_cnt >= rx_thr);
    assign tx_irq     = (tx_cnt <= tx_thr);
    assign stat_flags = {tx_empty, rx_full, tx_full, rx_empty};

    AST_RX_IRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_irq); // R5

    AST_TX_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_irq); // R6

    AST_BYPASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !en_q) |-> (rx_cnt <= CW'(1) && tx_cnt <= CW'(1))); // R7

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && tx_empty)); // R10

endmodule

// File: tb/uart_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_pair_tb_top;
    localparam int DEPTH = 16;
    localparam int TOUT  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic [5:0]  lvl_sel = '0;
    logic        bit_tick = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic [2:0]  rx_push_err = '0;
    logic        rx_pop = 1'b0;
    logic [11:0] rx_pop_data;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_push_data = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_pop_data;
    logic [3:0]  stat_flags;
    logic        rx_irq, tx_irq, rx_timeout;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_fifo_pair #(.DEPTH(DEPTH), .TOUT_BITS(TOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lvl_sel(lvl_sel),
        .bit_tick(bit_tick), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .stat_flags(stat_flags), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .rx_timeout(rx_timeout)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lvl(input int code);
        case (code)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            3: return DEPTH * 3 / 4;
            default: return DEPTH * 7 / 8;
        endcase
    endfunction

    task automatic rx_wr(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_push_data = d; rx_push_err = e;
        step();
        rx_push = 1'b0;
    endtask

    task automatic rx_rd(output logic [11:0] v);
        v = rx_pop_data;
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic tx_wr(input logic [7:0] d);
        tx_push = 1'b1; tx_push_data = d;
        step();
        tx_push = 1'b0;
    endtask

    task automatic tx_rd(output logic [7:0] v);
        v = tx_pop_data;
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(stat_flags == 4'b1001, "R1 flags", stat_flags, 4'b1001);
        chk(rx_irq == 1'b0, "R1 rx_irq", rx_irq, 0);
        chk(tx_irq == 1'b1, "R1 tx_irq", tx_irq, 1);
        chk(rx_timeout == 1'b0, "R1 timeout", rx_timeout, 0);
    endtask

    task automatic t_rx_order();
        logic [11:0] v;
        rx_wr(8'hA1, 3'b001);
        rx_wr(8'h5B, 3'b010);
        rx_wr(8'hC3, 3'b100);
        rx_rd(v); chk(v == 12'h1A1, "R2 entry0", v, 12'h1A1);
        rx_rd(v); chk(v == 12'h25B, "R2 entry1", v, 12'h25B);
        rx_rd(v); chk(v == 12'h4C3, "R2 entry2", v, 12'h4C3);
        chk(stat_flags[0] == 1'b1, "R2 rx empty after drain", stat_flags, 1);
    endtask

    task automatic t_tx_full();
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) tx_wr(8'(i + 8'h40));
        chk(stat_flags[1] == 1'b1, "R3 tx full", stat_flags, 4'b0010);
        chk(stat_flags[3] == 1'b0, "R3 tx not empty", stat_flags, 0);
        tx_wr(8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            tx_rd(v);
            chk(v == 8'(i + 8'h40), "R3 tx data", v, 8'(i + 8'h40));
        end
        chk(stat_flags[3] == 1'b1, "R3 tx empty, extra push dropped", stat_flags, 4'b1000);
    endtask

    task automatic t_rx_overrun();
        logic [11:0] v;
        for (int i = 0; i < DEPTH; i++) rx_wr(8'(i), 3'b000);
        chk(stat_flags[2] == 1'b1, "R3 rx full", stat_flags, 4'b0100);
        rx_wr(8'h55, 3'b000);
        for (int i = 0; i < DEPTH; i++) begin
            logic [11:0] e;
            e = (i == DEPTH - 1) ? (12'h800 | 12'(i)) : 12'(i);
            rx_rd(v);
            chk(v == e, "R4 overrun entry", v, e);
        end
        chk(stat_flags[0] == 1'b1, "R4 rx empty", stat_flags, 1);
    endtask

    task automatic t_rx_level();
        logic [11:0] v;
        for (int c = 0; c < 8; c++) begin
            lvl_sel = {3'(c), 3'b000};
            for (int k = 0; k <= DEPTH; k++) begin
                chk(rx_irq == (k >= lvl(c)), "R5 rx_irq", rx_irq, 32'(k >= lvl(c)));
                if (k < DEPTH) rx_wr(8'(k), 3'b000);
            end
            for (int k = 0; k < DEPTH; k++) rx_rd(v);
        end
    endtask

    task automatic t_tx_level();
        logic [7:0] v;
        for (int c = 0; c < 8; c++) begin
            lvl_sel = {3'b000, 3'(c)};
            for (int k = 0; k <= DEPTH; k++) begin
                chk(tx_irq == (k <= lvl(c)), "R6 tx_irq", tx_irq, 32'(k <= lvl(c)));
                if (k < DEPTH) tx_wr(8'(k));
            end
            for (int k = 0; k < DEPTH; k++) tx_rd(v);
        end
        lvl_sel = '0;
    endtask

    task automatic t_bypass();
        logic [11:0] v;
        logic [7:0]  t;
        rx_wr(8'h11, 3'b000);
        rx_wr(8'h22, 3'b000);
        tx_wr(8'h33);
        fifo_en = 1'b0;
        rx_push = 1'b1; rx_push_data = 8'h99;
        step();
        rx_push = 1'b0;
        chk(stat_flags == 4'b1001, "R10 flush on mode change", stat_flags, 4'b1001);
        chk(rx_irq == 1'b0, "R7 rx_irq empty", rx_irq, 0);
        rx_wr(8'h61, 3'b000);
        chk(stat_flags[2] == 1'b1, "R7 rx full at one", stat_flags, 4'b0100);
        chk(rx_irq == 1'b1, "R7 rx_irq held", rx_irq, 1);
        rx_wr(8'h62, 3'b000);
        rx_rd(v);
        chk(v == 12'h861, "R7 held entry overrun", v, 12'h861);
        tx_wr(8'h71);
        chk(stat_flags[1] == 1'b1, "R7 tx full at one", stat_flags, 4'b0010);
        chk(tx_irq == 1'b0, "R7 tx_irq when held", tx_irq, 0);
        tx_wr(8'h72);
        tx_rd(t);
        chk(t == 8'h71, "R7 tx held data", t, 8'h71);
        chk(tx_irq == 1'b1, "R7 tx_irq empty", tx_irq, 1);
        fifo_en = 1'b1;
        step();
        chk(stat_flags == 4'b1001, "R10 flush on re-enable", stat_flags, 4'b1001);
    endtask

    task automatic t_timeout();
        logic [11:0] v;
        rx_wr(8'h01, 3'b000);
        step();
        ticks(TOUT - 1);
        chk(rx_timeout == 1'b0, "R8 no timeout before window", rx_timeout, 0);
        ticks(1);
        chk(rx_timeout == 1'b1, "R8 timeout after window", rx_timeout, 1);
        rx_wr(8'h02, 3'b000);
        chk(rx_timeout == 1'b0, "R8 cleared by push", rx_timeout, 0);
        ticks(TOUT - 1);
        bit_tick = 1'b1; rx_push = 1'b1; rx_push_data = 8'h03;
        step();
        bit_tick = 1'b0; rx_push = 1'b0;
        chk(rx_timeout == 1'b0, "R8 push on last tick", rx_timeout, 0);
        ticks(TOUT);
        chk(rx_timeout == 1'b1, "R8 fired again", rx_timeout, 1);
        rx_rd(v);
        chk(rx_timeout == 1'b0, "R8 cleared by pop", rx_timeout, 0);
        rx_rd(v);
        rx_rd(v);
        ticks(TOUT + 8);
        chk(rx_timeout == 1'b0, "R8 silent when empty", rx_timeout, 0);
    endtask

    task automatic t_swap();
        logic [11:0] v;
        for (int i = 0; i < DEPTH; i++) rx_wr(8'(i + 8'h20), 3'b000);
        v = rx_pop_data;
        rx_pop = 1'b1; rx_push = 1'b1; rx_push_data = 8'hF0; rx_push_err = 3'b010;
        step();
        rx_pop = 1'b0; rx_push = 1'b0; rx_push_err = 3'b000;
        chk(v == 12'h020, "R9 popped head", v, 12'h020);
        chk(stat_flags[2] == 1'b1, "R9 still full", stat_flags, 4'b0100);
        for (int i = 1; i < DEPTH; i++) begin
            rx_rd(v);
            chk(v == 12'(i + 8'h20), "R9 middle entry", v, 12'(i + 8'h20));
        end
        rx_rd(v);
        chk(v == 12'h2F0, "R9 tail without overrun", v, 12'h2F0);
    endtask

    task automatic t_pop_empty();
        logic [11:0] v;
        logic [7:0]  t;
        rx_pop = 1'b1; tx_pop = 1'b1;
        step(); step();
        rx_pop = 1'b0; tx_pop = 1'b0;
        chk(stat_flags == 4'b1001, "R11 still empty", stat_flags, 4'b1001);
        rx_wr(8'h7E, 3'b000);
        tx_wr(8'h7F);
        rx_rd(v);
        chk(v == 12'h07E, "R11 rx data intact", v, 12'h07E);
        tx_rd(t);
        chk(t == 8'h7F, "R11 tx data intact", t, 8'h7F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_rx_order();
        t_tx_full();
        t_rx_overrun();
        t_rx_level();
        t_tx_level();
        t_bypass();
        t_timeout();
        t_swap();
        t_pop_empty();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule